// File: doc/BRIEF.md
# Buffered Serial Transmitter with Ninth Bit and Break

This block turns characters handed over by a host into an asynchronous serial stream on a single output line. A one-entry holding stage sits in front of the shift stage. The host can queue the next character while the current one is still leaving the line. The host writes an 8-bit value, plus an optional ninth bit that it supplies itself. Whether a frame carries 8 or 9 data bits is chosen by a mode input, which is sampled when the character is written. A write may instead request a long break character, as bus systems of the LIN kind use for synchronisation.

Bit timing is not generated inside the block. A one-cycle `bit_tick` strobe from an external rate divider marks each bit period, and the line changes only on that strobe. Two status outputs tell the host what it may do next. `hold_free` says that a new character can be written. `shift_empty` says that nothing is being sent. A request output reports the free holding stage when the host has enabled it. While `tx_en` is low the block sends nothing and discards queued work.

Top module: `uart_tx9_top`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_free` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: While `tx_en` is 0, writes are ignored, `tx_line` stays 1 and `shift_empty` is 1. Lowering `tx_en` during a frame returns the line to 1 and empties both stages one cycle later.
- R3: A write (`wr_valid` high for one cycle) into a free holding stage clears `hold_free` on the following cycle. A write while `hold_free` is 0 is ignored and its character is never sent.
- R4: On a `bit_tick` where the shifter is empty and the holding stage is full, the character moves into the shifter. After that edge `tx_line` shows the start bit 0, `hold_free` is 1 and `shift_empty` is 0.
- R5: An 8-bit frame (`nine_en` 0 at write time) is 10 bits long: start 0, the data bits least significant first, then a stop bit of 1. Each following `bit_tick` presents the next bit.
- R6: A 9-bit frame (`nine_en` 1 at write time) is 11 bits long. Bit position 9, between data bit 7 and the stop bit, carries `wr_bit9`. In 8-bit frames `wr_bit9` has no effect.
- R7: A write with `wr_brk` 1 sends 13 bits of 0 and then a stop bit of 1, whatever `wr_data` holds.
- R8: `shift_empty` returns to 1, with `tx_line` 1, on the first `bit_tick` after the stop bit has been shown.
- R9: `irq` is 1 exactly when `int_en` is 1 and `hold_free` is 1.
- R10: Between `bit_tick` strobes, `tx_line` does not change while `tx_en` stays 1.
- R11: A character queued behind a frame starts on the `bit_tick` after the one on which the shifter became empty. This leaves one idle bit period of 1 between back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable; low clears and silences the block |
| bit_tick | input | 1 | One-cycle strobe marking each bit period |
| nine_en | input | 1 | Selects 9-bit frames for the character being written |
| int_en | input | 1 | Enables the holding-stage-free request |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character data |
| wr_bit9 | input | 1 | Ninth data bit, used in 9-bit frames |
| wr_brk | input | 1 | The write requests a break character |
| tx_line | output | 1 | Serial output, idle high |
| hold_free | output | 1 | Holding stage can accept a character |
| shift_empty | output | 1 | Shifter holds nothing |
| irq | output | 1 | Holding stage free request, gated by `int_en` |

## Verification
The hardest state to reach is a full holding stage that is waiting behind a frame in progress, while a further write arrives that must be dropped. This is what shows the idle gap of R11 and the dropped write of R3. The bench reaches it by writing one character, issuing the single tick that moves it into the shifter, and then writing two more characters before the next tick. It then follows the line through the first frame, the idle bit, the second frame, and one extra tick that shows the third character never appears. A separate directed step lowers `tx_en` in the middle of a frame to check the abort path.

// File: rtl/uart_tx9_pkg.sv
// Package: shared types for the buffered serial transmitter.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package uart_tx9_pkg;

    // Kind of character stored in the holding stage
    typedef enum logic [1:0] {
        KIND_D8  = 2'd0,
        KIND_D9  = 2'd1,
        KIND_BRK = 2'd2
    } tx_kind_e;

    // Larger of two integers, used to size the frame vector
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/uart_tx9_hold.sv
// Module: one-entry holding stage ahead of the shifter.
// Captures a character, its ninth bit and its kind (8-bit, 9-bit, break)
// when free. Releases it when the shifter takes it. Writes while full or
// while disabled are dropped. Assumes `take` is only raised while full.
module uart_tx9_hold
    import uart_tx9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              wr_brk,
    input  logic              nine_en,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output tx_kind_e          kind
);

    logic wr_acc;

    // Accept a write only when enabled and empty
    always_comb begin
        wr_acc = wr_valid && tx_en && !full;
    end

    // Occupancy flag: set on accepted write, cleared on take or disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (!tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_acc) begin
            full <= 1'b1;
        end
    end

    // Payload capture, including the frame kind fixed at write time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            bit9 <= 1'b0;
            kind <= KIND_D8;
        end else if (wr_acc) begin
            data <= wr_data;
            bit9 <= wr_bit9;
            if (wr_brk) begin
                kind <= KIND_BRK;
            end else if (nine_en) begin
                kind <= KIND_D9;
            end else begin
                kind <= KIND_D8;
            end
        end
    end

    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !full) else $error("take did not free holding stage"); // R4

    AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take && tx_en) |=> ($stable(data) && $stable(bit9) && full))
        else $error("holding stage overwritten while full"); // R3

endmodule

// File: rtl/uart_tx9_fmt.sv
// Module: combinational frame builder.
// Builds the bit vector that goes out least significant bit first (start,
// data, optional ninth bit, stop, or a run of zeros for a break) and its
// length in bit periods. Unused upper positions are filled with 1.
module uart_tx9_fmt
    import uart_tx9_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 13,
    parameter int FW      = 14,
    parameter int CW      = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  tx_kind_e          kind,
    output logic [FW-1:0]     frame,
    output logic [CW-1:0]     len
);

    localparam logic [CW-1:0] LEN_D8  = CW'(DATA_W + 2);
    localparam logic [CW-1:0] LEN_D9  = CW'(DATA_W + 3);
    localparam logic [CW-1:0] LEN_BRK = CW'(BRK_LEN + 1);

    // Assemble frame bits and length for the stored kind
    always_comb begin
        frame = '1;
        len   = LEN_D8;
        case (kind)
            KIND_D9: begin
                frame[0]          = 1'b0;
                frame[DATA_W:1]   = data;
                frame[DATA_W+1]   = bit9;
                len               = LEN_D9;
            end
            KIND_BRK: begin
                frame[BRK_LEN-1:0] = '0;
                len                = LEN_BRK;
            end
            default: begin
                frame[0]        = 1'b0;
                frame[DATA_W:1] = data;
                len             = LEN_D8;
            end
        endcase
    end

endmodule

// File: rtl/uart_tx9_shift.sv
// Module: transmit shifter.
// Loads a frame from the holding stage on a bit tick when idle, then
// presents one bit per tick on a registered line output. It goes idle on
// the tick after the last bit. Assumes bit_tick is a single-cycle strobe.
module uart_tx9_shift #(
    parameter int FW = 14,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          bit_tick,
    input  logic          hold_full,
    input  logic [FW-1:0] frame,
    input  logic [CW-1:0] len,
    output logic          take,
    output logic          busy,
    output logic          line
);

    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [FW-1:0] sr;
    logic [CW-1:0] cnt;

    // Transfer request: idle shifter, queued character, tick present
    always_comb begin
        take = bit_tick && tx_en && !busy && hold_full;
    end

    // Shift register, bit counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (!tx_en) begin
            sr   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sr   <= frame;
            cnt  <= len;
            busy <= 1'b1;
        end else if (bit_tick && busy) begin
            if (cnt == CNT_LAST) begin
                sr   <= '1;
                cnt  <= '0;
                busy <= 1'b0;
            end else begin
                sr  <= {1'b1, sr[FW-1:1]};
                cnt <= cnt - CNT_LAST;
            end
        end
    end

    // Line output is the low end of the register
    always_comb begin
        line = sr[0];
    end

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !line)) else $error("no start bit after load"); // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line) else $error("line low while idle"); // R8

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && tx_en) |=> $stable(sr)) else $error("line moved without tick"); // R10

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (line && !busy)) else $error("active while disabled"); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt >= CNT_LAST && int'(cnt) <= FW)) else $error("bit count out of range"); // R5

endmodule

// File: rtl/uart_tx9_top.sv
// Module: buffered serial transmitter top.
// Joins the holding stage, frame builder and shifter and derives the status
// and request outputs. Assumes an external divider supplies bit_tick.
module uart_tx9_top
    import uart_tx9_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              nine_en,
    input  logic              int_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              wr_brk,
    output logic              tx_line,
    output logic              hold_free,
    output logic              shift_empty,
    output logic              irq
);

    localparam int FW = max_int(DATA_W + 3, BRK_LEN + 1);
    localparam int CW = $clog2(FW + 1);

    logic              h_full;
    logic [DATA_W-1:0] h_data;
    logic              h_bit9;
    tx_kind_e          h_kind;
    logic [FW-1:0]     f_frame;
    logic [CW-1:0]     f_len;
    logic              s_take;
    logic              s_busy;

    uart_tx9_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_bit9  (wr_bit9),
        .wr_brk   (wr_brk),
        .nine_en  (nine_en),
        .take     (s_take),
        .full     (h_full),
        .data     (h_data),
        .bit9     (h_bit9),
        .kind     (h_kind)
    );

    uart_tx9_fmt #(.DATA_W(DATA_W), .BRK_LEN(BRK_LEN), .FW(FW), .CW(CW)) u_fmt (
        .data  (h_data),
        .bit9  (h_bit9),
        .kind  (h_kind),
        .frame (f_frame),
        .len   (f_len)
    );

    uart_tx9_shift #(.FW(FW), .CW(CW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_tick  (bit_tick),
        .hold_full (h_full),
        .frame     (f_frame),
        .len       (f_len),
        .take      (s_take),
        .busy      (s_busy),
        .line      (tx_line)
    );

    // Status and request outputs
    always_comb begin
        hold_free   = !h_full;
        shift_empty = !s_busy;
        irq         = int_en && !h_full;
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_en && hold_free && !bit_tick) |=> !hold_free)
        else $error("write did not fill holding stage"); // R3

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx_line) else $error("line low with empty shifter"); // R8

    AST_REQ_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (hold_free && int_en)) else $error("request without free stage"); // R9

endmodule

// File: tb/sim_uart_tx9_top.sv
// Bench for uart_tx9_top: table-driven frame checks, then directed tests.
module sim_uart_tx9_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       nine_en = 1'b0;
    logic       int_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit9 = 1'b0;
    logic       wr_brk = 1'b0;
    logic       tx_line;
    logic       hold_free;
    logic       shift_empty;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_tx9_top u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .nine_en(nine_en), .int_en(int_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_brk(wr_brk),
        .tx_line(tx_line), .hold_free(hold_free),
        .shift_empty(shift_empty), .irq(irq)
    );

    // Vector: {brk, nine, bit9, data[7:0], expected length[3:0]}
    localparam int NV = 6;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 4'd10},
        {1'b0, 1'b0, 1'b1, 8'h3C, 4'd10},
        {1'b0, 1'b1, 1'b1, 8'h81, 4'd11},
        {1'b0, 1'b1, 1'b0, 8'hFF, 4'd11},
        {1'b0, 1'b0, 1'b0, 8'h00, 4'd10},
        {1'b1, 1'b0, 1'b0, 8'hFF, 4'd14}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected line value at bit position idx, from R5, R6, R7
    function automatic logic exp_bit(input logic brk, input logic nine,
                                     input logic b9, input logic [7:0] d, input int idx);
        if (brk) return (idx < 13) ? 1'b0 : 1'b1;
        if (idx == 0) return 1'b0;
        if (idx <= 8) return d[idx-1];
        if (nine && idx == 9) return b9;
        return 1'b1;
    endfunction

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic write(input logic [7:0] d, input logic b9, input logic nine, input logic brk);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_bit9 = b9; nine_en = nine; wr_brk = brk;
        @(negedge clk);
        wr_valid = 1'b0; wr_brk = 1'b0;
    endtask

    // Check bits 1..len-1 of a frame already started, then the empty tick
    task automatic follow(input string req, input logic brk, input logic nine,
                          input logic b9, input logic [7:0] d, input int len);
        for (int k = 1; k < len; k++) begin
            tick();
            check(req, tx_line, exp_bit(brk, nine, b9, d, k));
            check("R8 busy during frame", shift_empty, 0);
        end
        tick();
        check("R8 empty after stop", shift_empty, 1);
        check("R8 line high when empty", tx_line, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line", tx_line, 1);
        check("R1 hold_free", hold_free, 1);
        check("R1 shift_empty", shift_empty, 1);
        check("R1 irq", irq, 0);

        // R2: disabled, write ignored
        write(8'h00, 1'b0, 1'b0, 1'b0);
        check("R2 write ignored", hold_free, 1);
        tick(); tick();
        check("R2 line stays high", tx_line, 1);
        check("R2 shifter empty", shift_empty, 1);

        tx_en = 1'b1;
        // Table walk: R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            logic brk, nine, b9;
            logic [7:0] d;
            int len;
            {brk, nine, b9, d} = VEC[v][14:4];
            len = int'(VEC[v][3:0]);
            write(d, b9, nine, brk);
            check("R3 write fills", hold_free, 0);
            tick();
            check("R4 start bit", tx_line, 0);
            check("R4 hold freed", hold_free, 1);
            check("R4 shifter busy", shift_empty, 0);
            follow(brk ? "R7 break bit" : (nine ? "R6 nine-bit frame" : "R5 eight-bit frame"),
                   brk, nine, b9, d, len);
        end

        // R9: request gating
        int_en = 1'b1;
        @(negedge clk);
        check("R9 irq when free", irq, 1);
        write(8'h12, 1'b0, 1'b0, 1'b0);
        check("R9 irq low when full", irq, 0);
        tick();
        check("R9 irq after transfer", irq, 1);
        // R10: line holds between ticks (start bit)
        repeat (5) @(negedge clk);
        check("R10 line held", tx_line, 0);
        follow("R5 frame after hold", 1'b0, 1'b0, 1'b0, 8'h12, 10);
        int_en = 1'b0;
        @(negedge clk);
        check("R9 irq gated off", irq, 0);

        // R11 and R3: back-to-back with a dropped third write
        write(8'h55, 1'b0, 1'b0, 1'b0);
        tick();
        write(8'h0F, 1'b0, 1'b0, 1'b0);
        check("R3 queued behind frame", hold_free, 0);
        write(8'hAA, 1'b0, 1'b0, 1'b0);
        check("R3 full write dropped", hold_free, 0);
        follow("R5 first of pair", 1'b0, 1'b0, 1'b0, 8'h55, 10);
        check("R11 still queued at empty", hold_free, 0);
        tick();
        check("R11 queued start", tx_line, 0);
        check("R11 hold freed", hold_free, 1);
        follow("R11 second of pair", 1'b0, 1'b0, 1'b0, 8'h0F, 10);
        tick();
        check("R3 dropped char not sent", tx_line, 1);
        check("R3 dropped shifter idle", shift_empty, 1);

        // R2: abort mid-frame
        write(8'h00, 1'b0, 1'b1, 1'b0);
        tick(); tick();
        check("R2 mid-frame low", tx_line, 0);
        tx_en = 1'b0;
        @(negedge clk);
        check("R2 abort line", tx_line, 1);
        check("R2 abort empty", shift_empty, 1);
        check("R2 abort hold", hold_free, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule